// File: doc/BRIEF.md
# Machine-Mode CSR and Trap Sequencer

This block holds the machine-level control and status registers of a single-hart 32-bit integer core and runs its synchronous exception flow. The pipeline hands it one decoded instruction per cycle: the class flags, the CSR operation code and address, the rs1 field and its register value, the PC, and the effective address and size of any memory access. The block executes the six CSR access operations. It detects the five supported exception causes. When an exception occurs, it records the trap state and steers fetch to the handler. An mret steers fetch back to the saved PC.

All results are registered and appear one cycle after the instruction is presented. The results are the old CSR value for the destination register, a flag that allows the writeback, a flag that allows the memory access, and a redirect request with its target. Trap vectoring is direct only. The status register is plain storage that neither trap entry nor mret ever modifies. Interrupts, lower privilege levels, delegation and timers are not present.

Top module: `mtrap_csr_unit`

## Requirements
- R1: When `in_is_csr` is set, `in_funct3` selects the operation. Value 1 is write, 2 is set bits and 3 is clear bits, each using `in_rs1_data` as the operand. Values 5, 6 and 7 are the same three operations using the zero-extended 5-bit `in_rs1_idx` field as the operand. Values 0 and 4 are illegal instructions.
- R2: The cycle after a legal CSR instruction, `csr_rdata` holds the value the CSR had before that instruction, and `wb_ok` is 1. For any instruction that is not a legal CSR access, `csr_rdata` is 0.
- R3: Set and clear operations (funct3 2, 3, 6, 7) do not write when `in_rs1_idx` is 0. Write operations (1, 5) always write.
- R4: The implemented addresses are 0x300 (status), 0x305 (trap base), 0x341 (exception PC), 0x342 (cause) and 0x343 (trap value), all read/write. Four addresses are read-only: 0x301 reads 0x40000100, and 0xF12, 0xF13 and 0xF14 read the ARCH_ID, IMP_ID and HART_ID parameters.
- R5: An access to an unimplemented address raises an illegal-instruction trap. So does an operation that would write a read-only address. In both cases no CSR changes except the trap state.
- R6: On a trap, the exception PC, cause and trap value are written on the same edge. The redirect target is the trap base with bits [1:0] cleared. `redirect_valid` is 1 and both `wb_ok` and `mem_ok` are 0.
- R7: The cause codes are illegal instruction 2, breakpoint 3, misaligned load 4, misaligned store 6 and environment call 11. The top bit of the cause is 0. When more than one condition is present, the priority is illegal, then breakpoint, then environment call, then load, then store.
- R8: `mem_size` is coded 0 for byte, 1 for halfword and 2 (or 3) for word. A halfword access is misaligned when address bit 0 is set. A word access is misaligned when either of address bits [1:0] is set. A misaligned access traps with the trap value set to the address. A correctly aligned access gives `mem_ok`=1. All other causes set the trap value to 0.
- R9: mret requests a redirect to the current exception PC, including any value software wrote there. It changes no CSR.
- R10: The status register keeps its value through trap entry and mret.
- R11: After reset, all outputs are 0, the trap base reads MTVEC_RESET and the other writable CSRs read 0. A cycle without `in_valid` produces all-zero outputs and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An instruction is presented this cycle |
| in_pc | input | 32 | PC of the instruction |
| in_is_csr | input | 1 | Instruction is a CSR access |
| in_funct3 | input | 3 | CSR operation code |
| in_csr_addr | input | 12 | CSR address |
| in_rs1_idx | input | 5 | rs1 field, also the immediate operand |
| in_rs1_data | input | 32 | Value of rs1 |
| in_is_ecall | input | 1 | Environment call |
| in_is_ebreak | input | 1 | Breakpoint |
| in_is_mret | input | 1 | Return from trap |
| in_illegal | input | 1 | Decoder found an illegal encoding |
| in_is_load | input | 1 | Instruction is a load |
| in_is_store | input | 1 | Instruction is a store |
| mem_addr | input | 32 | Effective memory address |
| mem_size | input | 2 | Access size code |
| out_valid | output | 1 | Results below belong to the last presented instruction |
| csr_rdata | output | 32 | Old CSR value for rd |
| wb_ok | output | 1 | Register writeback allowed |
| mem_ok | output | 1 | Memory access allowed |
| redirect_valid | output | 1 | Fetch must be redirected |
| redirect_pc | output | 32 | Redirect target |

## Verification
The clocked properties assume that the decoder asserts at most one instruction class per cycle, with `in_illegal` as the only flag that may join another. Under that assumption, an aligned load with no other flag must pass and every mret must redirect. The stimulus keeps to this assumption, with one exception: a single priority check combines the illegal and environment-call flags. It is built so that no property whose antecedent excludes `in_illegal` can be triggered by it. The main stimulus is a sweep over every implemented address plus one unimplemented address, all eight operation codes, and both zero and nonzero rs1 fields. A bench model computes each old value, update and trap, and the trap state is read back through normal CSR reads.

// File: rtl/mtrap_pkg.sv
package mtrap_pkg;
  localparam int XLEN   = 32;
  localparam int CAUSEW = 5;

  localparam logic [11:0] A_STATUS = 12'h300;
  localparam logic [11:0] A_ISA    = 12'h301;
  localparam logic [11:0] A_TVEC   = 12'h305;
  localparam logic [11:0] A_EPC    = 12'h341;
  localparam logic [11:0] A_CAUSE  = 12'h342;
  localparam logic [11:0] A_TVAL   = 12'h343;
  localparam logic [11:0] A_ARCH   = 12'hF12;
  localparam logic [11:0] A_IMP    = 12'hF13;
  localparam logic [11:0] A_HART   = 12'hF14;

  localparam logic [XLEN-1:0] ISA_WORD = 32'h4000_0100;

  localparam logic [CAUSEW-1:0] C_ILLEGAL = 5'd2;
  localparam logic [CAUSEW-1:0] C_BREAK   = 5'd3;
  localparam logic [CAUSEW-1:0] C_LD_MIS  = 5'd4;
  localparam logic [CAUSEW-1:0] C_ST_MIS  = 5'd6;
  localparam logic [CAUSEW-1:0] C_ECALL   = 5'd11;

  typedef enum logic [3:0] {
    IX_NONE, IX_STATUS, IX_ISA, IX_TVEC, IX_EPC, IX_CAUSE, IX_TVAL,
    IX_ARCH, IX_IMP, IX_HART
  } csr_ix_e;

  typedef enum logic [1:0] {
    OP_BAD = 2'd0, OP_WRITE = 2'd1, OP_SET = 2'd2, OP_CLR = 2'd3
  } csr_op_e;

  function automatic logic misaligned(input logic [1:0] size,
                                      input logic [1:0] lo);
    if (size[1])      return |lo;
    else if (size[0]) return lo[0];
    else              return 1'b0;
  endfunction
endpackage

// File: rtl/mtrap_csr_decode.sv
module mtrap_csr_decode
  import mtrap_pkg::*;
(
  input  logic [11:0] addr,
  output csr_ix_e     ix,
  output logic        hit,
  output logic        read_only
);
  always_comb begin
    case (addr)
      A_STATUS: ix = IX_STATUS;
      A_ISA:    ix = IX_ISA;
      A_TVEC:   ix = IX_TVEC;
      A_EPC:    ix = IX_EPC;
      A_CAUSE:  ix = IX_CAUSE;
      A_TVAL:   ix = IX_TVAL;
      A_ARCH:   ix = IX_ARCH;
      A_IMP:    ix = IX_IMP;
      A_HART:   ix = IX_HART;
      default:  ix = IX_NONE;
    endcase
  end

  assign hit       = (ix != IX_NONE);
  // top two address bits 11 mark the read-only region; the ISA word is fixed too
  assign read_only = (addr[11:10] == 2'b11) || (ix == IX_ISA);
endmodule

// File: rtl/mtrap_exc_detect.sv
module mtrap_exc_detect
  import mtrap_pkg::*;
(
  input  logic              valid,
  input  logic              bad_insn,
  input  logic              is_ebreak,
  input  logic              is_ecall,
  input  logic              is_load,
  input  logic              is_store,
  input  logic [1:0]        size,
  input  logic [1:0]        addr_lo,
  output logic              trap,
  output logic [CAUSEW-1:0] cause,
  output logic              tval_is_addr
);
  logic mis;
  assign mis = misaligned(size, addr_lo);

  always_comb begin
    trap         = 1'b0;
    cause        = '0;
    tval_is_addr = 1'b0;
    if (valid) begin
      if (bad_insn) begin
        trap = 1'b1; cause = C_ILLEGAL;
      end else if (is_ebreak) begin
        trap = 1'b1; cause = C_BREAK;
      end else if (is_ecall) begin
        trap = 1'b1; cause = C_ECALL;
      end else if (is_load && mis) begin
        trap = 1'b1; cause = C_LD_MIS; tval_is_addr = 1'b1;
      end else if (is_store && mis) begin
        trap = 1'b1; cause = C_ST_MIS; tval_is_addr = 1'b1;
      end
    end
  end
endmodule

// File: rtl/mtrap_csr_regs.sv
module mtrap_csr_regs
  import mtrap_pkg::*;
#(
  parameter logic [XLEN-1:0] TVEC_RST = 32'h0000_0100,
  parameter logic [XLEN-1:0] ARCH_ID  = 32'h0000_0001,
  parameter logic [XLEN-1:0] IMP_ID   = 32'h0000_0002,
  parameter logic [XLEN-1:0] HART_ID  = 32'h0000_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  csr_ix_e           ix,
  input  logic              wr_en,
  input  logic [XLEN-1:0]   wr_data,
  input  logic              trap_we,
  input  logic [XLEN-1:0]   trap_pc,
  input  logic [CAUSEW-1:0] trap_cause,
  input  logic [XLEN-1:0]   trap_tval,
  output logic [XLEN-1:0]   rd_data,
  output logic [XLEN-1:0]   tvec_q,
  output logic [XLEN-1:0]   epc_q
);
  logic [XLEN-1:0] status_q, cause_q, tval_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      tvec_q   <= TVEC_RST;
      epc_q    <= '0;
      cause_q  <= '0;
      tval_q   <= '0;
    end else if (trap_we) begin
      epc_q   <= trap_pc;
      cause_q <= {{(XLEN-CAUSEW){1'b0}}, trap_cause};
      tval_q  <= trap_tval;
    end else if (wr_en) begin
      case (ix)
        IX_STATUS: status_q <= wr_data;
        IX_TVEC:   tvec_q   <= wr_data;
        IX_EPC:    epc_q    <= wr_data;
        IX_CAUSE:  cause_q  <= wr_data;
        IX_TVAL:   tval_q   <= wr_data;
        default:   ;
      endcase
    end
  end

  always_comb begin
    case (ix)
      IX_STATUS: rd_data = status_q;
      IX_ISA:    rd_data = ISA_WORD;
      IX_TVEC:   rd_data = tvec_q;
      IX_EPC:    rd_data = epc_q;
      IX_CAUSE:  rd_data = cause_q;
      IX_TVAL:   rd_data = tval_q;
      IX_ARCH:   rd_data = ARCH_ID;
      IX_IMP:    rd_data = IMP_ID;
      IX_HART:   rd_data = HART_ID;
      default:   rd_data = '0;
    endcase
  end
endmodule

// File: rtl/mtrap_csr_unit.sv
module mtrap_csr_unit
  import mtrap_pkg::*;
#(
  parameter logic [31:0] MTVEC_RESET = 32'h0000_0100,
  parameter logic [31:0] ARCH_ID     = 32'h0000_0001,
  parameter logic [31:0] IMP_ID      = 32'h0000_0002,
  parameter logic [31:0] HART_ID     = 32'h0000_0000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  input  logic [31:0] in_pc,
  input  logic        in_is_csr,
  input  logic [2:0]  in_funct3,
  input  logic [11:0] in_csr_addr,
  input  logic [4:0]  in_rs1_idx,
  input  logic [31:0] in_rs1_data,
  input  logic        in_is_ecall,
  input  logic        in_is_ebreak,
  input  logic        in_is_mret,
  input  logic        in_illegal,
  input  logic        in_is_load,
  input  logic        in_is_store,
  input  logic [31:0] mem_addr,
  input  logic [1:0]  mem_size,
  output logic        out_valid,
  output logic [31:0] csr_rdata,
  output logic        wb_ok,
  output logic        mem_ok,
  output logic        redirect_valid,
  output logic [31:0] redirect_pc
);
  localparam int IMMW = 5;

  csr_ix_e           ix;
  csr_op_e           op;
  logic              hit, ro, wants_write, csr_bad, trap, tval_is_addr, csr_we;
  logic [CAUSEW-1:0] cause;
  logic [XLEN-1:0]   operand, old_val, new_val, tvec_q, epc_q, tval;

  mtrap_csr_decode u_dec (
    .addr(in_csr_addr), .ix(ix), .hit(hit), .read_only(ro)
  );

  assign op          = csr_op_e'(in_funct3[1:0]);
  assign operand     = in_funct3[2] ? {{(XLEN-IMMW){1'b0}}, in_rs1_idx} : in_rs1_data;
  assign wants_write = (op == OP_WRITE) || (in_rs1_idx != '0);
  assign csr_bad     = in_is_csr && ((op == OP_BAD) || !hit || (ro && wants_write));

  mtrap_exc_detect u_exc (
    .valid(in_valid), .bad_insn(in_illegal || csr_bad),
    .is_ebreak(in_is_ebreak), .is_ecall(in_is_ecall),
    .is_load(in_is_load), .is_store(in_is_store),
    .size(mem_size), .addr_lo(mem_addr[1:0]),
    .trap(trap), .cause(cause), .tval_is_addr(tval_is_addr)
  );

  always_comb begin
    case (op)
      OP_SET:  new_val = old_val | operand;
      OP_CLR:  new_val = old_val & ~operand;
      default: new_val = operand;
    endcase
  end

  assign csr_we = in_valid && in_is_csr && !trap && wants_write;
  assign tval   = tval_is_addr ? mem_addr : '0;

  mtrap_csr_regs #(
    .TVEC_RST(MTVEC_RESET), .ARCH_ID(ARCH_ID), .IMP_ID(IMP_ID), .HART_ID(HART_ID)
  ) u_regs (
    .clk(clk), .rst(rst), .ix(ix),
    .wr_en(csr_we), .wr_data(new_val),
    .trap_we(trap), .trap_pc(in_pc), .trap_cause(cause), .trap_tval(tval),
    .rd_data(old_val), .tvec_q(tvec_q), .epc_q(epc_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid      <= 1'b0;
      csr_rdata      <= '0;
      wb_ok          <= 1'b0;
      mem_ok         <= 1'b0;
      redirect_valid <= 1'b0;
      redirect_pc    <= '0;
    end else begin
      out_valid      <= in_valid;
      csr_rdata      <= (in_valid && in_is_csr && !trap) ? old_val : '0;
      wb_ok          <= in_valid && !trap;
      mem_ok         <= in_valid && !trap && (in_is_load || in_is_store);
      redirect_valid <= in_valid && (trap || in_is_mret);
      if (in_valid && trap)            redirect_pc <= {tvec_q[XLEN-1:2], 2'b00};
      else if (in_valid && in_is_mret) redirect_pc <= epc_q;
      else                             redirect_pc <= '0;
    end
  end
endmodule

// File: rtl/mtrap_csr_unit_chk.sv
module mtrap_csr_unit_chk (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic        in_is_csr,
  input logic [2:0]  in_funct3,
  input logic [11:0] in_csr_addr,
  input logic        in_is_ecall,
  input logic        in_is_ebreak,
  input logic        in_is_mret,
  input logic        in_illegal,
  input logic        in_is_load,
  input logic        in_is_store,
  input logic [31:0] mem_addr,
  input logic [1:0]  mem_size,
  input logic        out_valid,
  input logic [31:0] csr_rdata,
  input logic        wb_ok,
  input logic        mem_ok,
  input logic        redirect_valid,
  input logic [31:0] redirect_pc
);
  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid && !redirect_valid && !wb_ok && !mem_ok && csr_rdata == '0);

  assert_ecall_vectors_R6: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_is_ecall |=> redirect_valid && redirect_pc[1:0] == 2'b00 && !wb_ok && !mem_ok);

  assert_word_misalign_R8: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_is_load && mem_size == 2'd2 && mem_addr[1:0] != 2'b00
    |=> !mem_ok && !wb_ok && redirect_valid);

  assert_byte_passes_R8: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_is_load && mem_size == 2'd0 && !in_illegal && !in_is_csr
    && !in_is_ecall && !in_is_ebreak |=> mem_ok && wb_ok && !redirect_valid);

  assert_mret_redirects_R9: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_is_mret && !in_illegal && !in_is_csr && !in_is_ecall && !in_is_ebreak
    && !in_is_load && !in_is_store |=> redirect_valid && wb_ok && csr_rdata == '0);

  assert_noncsr_zero_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid && !in_is_csr |=> csr_rdata == '0);

  assert_ro_write_traps_R5: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_is_csr && in_csr_addr[11:10] == 2'b11 && in_funct3[1:0] == 2'b01
    |=> redirect_valid && !wb_ok);

  assert_bad_funct_R1: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_is_csr && in_funct3[1:0] == 2'b00 |=> redirect_valid && !wb_ok);

  assert_single_owner_R6: assert property (@(posedge clk) disable iff (rst)
    $countones({redirect_valid && !wb_ok, mem_ok && redirect_valid}) <= 1);
endmodule

bind mtrap_csr_unit mtrap_csr_unit_chk u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_is_csr(in_is_csr),
  .in_funct3(in_funct3), .in_csr_addr(in_csr_addr), .in_is_ecall(in_is_ecall),
  .in_is_ebreak(in_is_ebreak), .in_is_mret(in_is_mret), .in_illegal(in_illegal),
  .in_is_load(in_is_load), .in_is_store(in_is_store), .mem_addr(mem_addr),
  .mem_size(mem_size), .out_valid(out_valid), .csr_rdata(csr_rdata), .wb_ok(wb_ok),
  .mem_ok(mem_ok), .redirect_valid(redirect_valid), .redirect_pc(redirect_pc)
);

// File: tb/sim_mtrap_csr_unit.sv
`timescale 1ns/1ps
module sim_mtrap_csr_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid, in_is_csr, in_is_ecall, in_is_ebreak, in_is_mret;
  logic        in_illegal, in_is_load, in_is_store;
  logic [31:0] in_pc, in_rs1_data, mem_addr;
  logic [2:0]  in_funct3;
  logic [11:0] in_csr_addr;
  logic [4:0]  in_rs1_idx;
  logic [1:0]  mem_size;
  logic        out_valid, wb_ok, mem_ok, redirect_valid;
  logic [31:0] csr_rdata, redirect_pc;

  int checks = 0;
  int failures = 0;
  logic [31:0] pc_ctr = 32'h0000_1000;
  logic [31:0] m_status = 0, m_tvec = 32'h100, m_epc = 0, m_cause = 0, m_tval = 0;

  always #4 clk = ~clk;

  mtrap_csr_unit u0 (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic clear_in();
    in_valid = 0; in_is_csr = 0; in_is_ecall = 0; in_is_ebreak = 0; in_is_mret = 0;
    in_illegal = 0; in_is_load = 0; in_is_store = 0; in_pc = 0; in_rs1_data = 0;
    mem_addr = 0; in_funct3 = 0; in_csr_addr = 0; in_rs1_idx = 0; mem_size = 0;
  endtask

  task automatic fire();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic bit m_impl(input logic [11:0] a);
    return a == 12'h300 || a == 12'h301 || a == 12'h305 || a == 12'h341 || a == 12'h342 ||
           a == 12'h343 || a == 12'hF12 || a == 12'hF13 || a == 12'hF14;
  endfunction

  function automatic bit m_ro(input logic [11:0] a);
    return a == 12'h301 || a == 12'hF12 || a == 12'hF13 || a == 12'hF14;
  endfunction

  function automatic logic [31:0] m_read(input logic [11:0] a);
    case (a)
      12'h300: return m_status;
      12'h301: return 32'h4000_0100;
      12'h305: return m_tvec;
      12'h341: return m_epc;
      12'h342: return m_cause;
      12'h343: return m_tval;
      12'hF12: return 32'h1;
      12'hF13: return 32'h2;
      default: return 32'h0;
    endcase
  endfunction

  task automatic m_write(input logic [11:0] a, input logic [31:0] v);
    case (a)
      12'h300: m_status = v;
      12'h305: m_tvec = v;
      12'h341: m_epc = v;
      12'h342: m_cause = v;
      12'h343: m_tval = v;
      default: ;
    endcase
  endtask

  task automatic expect_out(input string req, input bit e_redir, input logic [31:0] e_pc,
                            input bit e_wb, input bit e_mem, input logic [31:0] e_rd);
    chk(out_valid == 1'b1, req, "out_valid", {31'b0, out_valid}, 32'h1);
    chk(redirect_valid == e_redir, req, "redirect_valid", {31'b0, redirect_valid}, {31'b0, e_redir});
    chk(redirect_pc == e_pc, req, "redirect_pc", redirect_pc, e_pc);
    chk(wb_ok == e_wb, req, "wb_ok", {31'b0, wb_ok}, {31'b0, e_wb});
    chk(mem_ok == e_mem, req, "mem_ok", {31'b0, mem_ok}, {31'b0, e_mem});
    chk(csr_rdata == e_rd, req, "csr_rdata", csr_rdata, e_rd);
  endtask

  // trap model: R6 capture and target, R7 cause
  task automatic take_trap(input string req, input logic [31:0] pc, input logic [31:0] cause,
                           input logic [31:0] tval);
    logic [31:0] tgt;
    tgt = {m_tvec[31:2], 2'b00};
    m_epc = pc; m_cause = cause; m_tval = tval;
    expect_out(req, 1'b1, tgt, 1'b0, 1'b0, 32'h0);
  endtask

  task automatic do_csr(input string req, input logic [2:0] f3, input logic [11:0] a,
                        input logic [4:0] idx, input logic [31:0] data);
    bit wr, legal;
    logic [31:0] old, src, nv, pc;
    clear_in();
    pc = pc_ctr; pc_ctr += 4;
    in_valid = 1; in_is_csr = 1; in_funct3 = f3; in_csr_addr = a; in_rs1_idx = idx;
    in_rs1_data = data; in_pc = pc;
    wr = (f3[1:0] == 2'd1) || (idx != 0);
    legal = (f3[1:0] != 2'd0) && m_impl(a) && !(m_ro(a) && wr);
    old = m_read(a);
    src = f3[2] ? {27'b0, idx} : data;
    case (f3[1:0])
      2'd2: nv = old | src;
      2'd3: nv = old & ~src;
      default: nv = src;
    endcase
    fire();
    if (legal) begin
      expect_out(req, 1'b0, 32'h0, 1'b1, 1'b0, old);
      if (wr) m_write(a, nv);
    end else begin
      take_trap(req, pc, 32'd2, 32'h0);
    end
  endtask

  task automatic do_mem(input string req, input bit st, input logic [1:0] sz,
                        input logic [31:0] addr);
    bit mis;
    logic [31:0] pc;
    clear_in();
    pc = pc_ctr; pc_ctr += 4;
    in_valid = 1; in_is_load = !st; in_is_store = st; mem_size = sz; mem_addr = addr; in_pc = pc;
    mis = sz[1] ? (addr[1:0] != 0) : (sz[0] ? addr[0] : 1'b0);
    fire();
    if (mis) take_trap(req, pc, st ? 32'd6 : 32'd4, addr);
    else     expect_out(req, 1'b0, 32'h0, 1'b1, 1'b1, 32'h0);
  endtask

  // kind: 0 ecall, 1 ebreak, 2 illegal, 3 mret, 4 illegal+ecall
  task automatic do_sys(input string req, input int kind);
    logic [31:0] pc;
    clear_in();
    pc = pc_ctr; pc_ctr += 4;
    in_valid = 1; in_pc = pc;
    in_is_ecall  = (kind == 0 || kind == 4);
    in_is_ebreak = (kind == 1);
    in_illegal   = (kind == 2 || kind == 4);
    in_is_mret   = (kind == 3);
    fire();
    case (kind)
      0: take_trap(req, pc, 32'd11, 32'h0);
      1: take_trap(req, pc, 32'd3, 32'h0);
      3: expect_out(req, 1'b1, m_epc, 1'b1, 1'b0, 32'h0);
      default: take_trap(req, pc, 32'd2, 32'h0);
    endcase
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL R11 watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    logic [11:0] addrs [10];
    addrs = '{12'h300, 12'h301, 12'h305, 12'h341, 12'h342, 12'h343,
              12'hF12, 12'hF13, 12'hF14, 12'h344};
    clear_in();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R11 reset state and idle cycle
    chk(out_valid == 0 && redirect_valid == 0 && wb_ok == 0 && mem_ok == 0,
        "R11", "reset flags", {28'b0, out_valid, redirect_valid, wb_ok, mem_ok}, 32'h0);
    chk(csr_rdata == 0 && redirect_pc == 0, "R11", "reset data", csr_rdata | redirect_pc, 32'h0);
    fire();
    chk(out_valid == 0 && redirect_valid == 0, "R11", "idle", {30'b0, out_valid, redirect_valid}, 32'h0);
    do_csr("R11", 3'd2, 12'h305, 5'd0, 32'hFFFF_FFFF);
    chk(csr_rdata == 32'h100, "R11", "tvec reset", csr_rdata, 32'h100);
    // R4 fixed values, literal expectations
    do_csr("R4", 3'd2, 12'h301, 5'd0, 32'h0);
    chk(csr_rdata == 32'h4000_0100, "R4", "isa word", csr_rdata, 32'h4000_0100);
    do_csr("R4", 3'd6, 12'hF13, 5'd0, 32'h0);
    chk(csr_rdata == 32'h2, "R4", "imp id", csr_rdata, 32'h2);
    // R1 R2 R3 R5 sweep over addresses, ops and rs1 field
    for (int i = 0; i < 10; i++)
      for (int f = 0; f < 8; f++)
        for (int k = 0; k < 2; k++) begin
          do_csr("R1", f[2:0], addrs[i], k ? 5'd19 : 5'd0,
                 32'hA5C3_0F96 ^ (32'(i) << 8) ^ (32'(f) << 20) ^ 32'(k * 32'h3C));
          do_csr("R3", 3'd2, addrs[i], 5'd0, 32'h0);
        end
    // R1 immediate zero extension
    do_csr("R1", 3'd5, 12'h343, 5'd31, 32'hFFFF_FFFF);
    do_csr("R1", 3'd2, 12'h343, 5'd0, 32'h0);
    chk(csr_rdata == 32'h1F, "R1", "imm extend", csr_rdata, 32'h1F);
    // R5 read-only write keeps value
    do_csr("R5", 3'd1, 12'hF12, 5'd4, 32'h55);
    do_csr("R5", 3'd2, 12'hF12, 5'd0, 32'h0);
    chk(csr_rdata == 32'h1, "R5", "ro unchanged", csr_rdata, 32'h1);
    // R6 R10 trap target masking and status preserved
    do_csr("R6", 3'd1, 12'h305, 5'd1, 32'h0000_2003);
    do_csr("R10", 3'd1, 12'h300, 5'd1, 32'hDEAD_BEEF);
    do_sys("R6", 0);
    chk(redirect_pc == 32'h2000, "R6", "masked base", redirect_pc, 32'h2000);
    do_sys("R7", 1);
    do_sys("R7", 2);
    do_sys("R7", 4);
    do_csr("R7", 3'd2, 12'h342, 5'd0, 32'h0);
    chk(csr_rdata == 32'd2, "R7", "priority cause", csr_rdata, 32'd2);
    // R8 misalignment sweep
    for (int s = 0; s < 4; s++)
      for (int lo = 0; lo < 4; lo++)
        for (int st = 0; st < 2; st++) begin
          do_mem("R8", st[0], s[1:0], 32'h8000_0040 | 32'(lo));
          do_csr("R8", 3'd2, 12'h343, 5'd0, 32'h0);
          do_csr("R7", 3'd2, 12'h342, 5'd0, 32'h0);
        end
    // R9 mret to software-advanced epc, R10 status unchanged
    do_sys("R9", 0);
    do_csr("R9", 3'd1, 12'h341, 5'd2, m_epc + 4);
    do_sys("R9", 3);
    chk(redirect_pc == m_epc, "R9", "mret target", redirect_pc, m_epc);
    do_csr("R10", 3'd2, 12'h300, 5'd0, 32'h0);
    chk(csr_rdata == 32'hDEAD_BEEF, "R10", "status kept", csr_rdata, 32'hDEAD_BEEF);
    clear_in();
    fire();
    chk(out_valid == 0 && redirect_valid == 0 && wb_ok == 0, "R11", "idle end",
        {29'b0, out_valid, redirect_valid, wb_ok}, 32'h0);
    summary();
    $finish;
  end
endmodule